// File: doc/BRIEF.md
# Transmit Frame FIFO With Start Threshold

This block is a byte-wide transmit buffer between a host-side write path and a MAC transmit read path. The host side writes frame bytes and marks the last byte of each frame. The MAC side reads bytes with a valid/ready handshake. Several whole frames can wait in the buffer at once, so the MAC can send them back to back without gaps that come from the buffer.

A frame is kept in storage until the MAC confirms it. The MAC pulses `tx_done` to release the bytes it has read since the frame began. It pulses `tx_retry` after a collision or an underrun, and reading then starts again at the frame's first byte. The host does not need to send the frame again. The write side measures free space from the oldest unconfirmed byte, so bytes that may still be replayed are never overwritten.

The MAC may begin a frame once the buffered byte count reaches a programmable threshold, or once the end of the frame is already in storage. If the MAC asks for a byte while the buffer is empty and the frame's end has not arrived, the block raises an underrun pulse.

Top module: `tx_replay_fifo`

## Requirements
- R1: After reset, `wr_ready` is 1. `rd_valid`, `start_ok` (with `start_thr` nonzero) and `underrun` are 0.
- R2: Bytes come out in the order they were written. Each byte's end-of-frame flag goes with it (`rd_eof` = 1 on the last byte).
- R3: With no bytes read or released, the buffer accepts exactly DEPTH (default 3072) bytes. `wr_ready` then drops to 0.
- R4: Reading bytes does not free space. `wr_ready` stays 0 until `tx_done` releases the bytes read.
- R5: `start_ok` is 1 when the count of unread bytes is at least `start_thr`.
- R6: `start_ok` is 1 when an unread end-of-frame byte is in storage, even if the count is below `start_thr`.
- R7: After a `tx_retry` pulse, the next byte read is the first byte of the current (unreleased) frame. The bytes that follow are repeated in order.
- R8: After a `tx_done` pulse, the bytes read since the frame began are freed. Reading continues with the next unread byte.
- R9: A cycle in which `rd_ready` = 1, no byte is available, and the current frame's end-of-frame byte has not been read is followed by exactly one cycle of `underrun` = 1. No pulse follows when the frame's end has already been read.
- R10: In a cycle with `tx_retry` or `tx_done` high, `rd_valid` is 0 and no byte is consumed. When both are high, the retry takes effect and the done is ignored.
- R11: After the end-of-frame byte of one frame is read, the first byte of the next queued frame is valid in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_data | input | 8 | Byte from the host side |
| wr_valid | input | 1 | Write request |
| wr_eof | input | 1 | Marks the written byte as the last of its frame |
| wr_ready | output | 1 | Space available; a write is taken when valid and ready |
| rd_data | output | 8 | Byte to the MAC |
| rd_valid | output | 1 | A byte is offered |
| rd_eof | output | 1 | The offered byte ends its frame |
| rd_ready | input | 1 | MAC takes the byte / requests a byte |
| tx_retry | input | 1 | Rewind reading to the current frame's first byte |
| tx_done | input | 1 | Release the bytes read since the frame began |
| start_thr | input | 12 | Start threshold in bytes |
| start_ok | output | 1 | The MAC may begin sending |
| underrun | output | 1 | One-cycle pulse: a byte was requested but none was available before the frame end |

## Verification
Every state change happens at the clock edge where a write, read, retry or done is accepted. `rd_valid`, `rd_data`, `wr_ready` and `start_ok` are combinational from that state, so they show the new value in the cycle right after that edge. `underrun` has one extra register, so it is high in the cycle after the starved request and low again one cycle later. The bench drives inputs on the falling edge and samples one time unit later, within the same cycle the handshake is judged in. It advances its scoreboard only after the rising edge that completes the handshake. That scoreboard is a queue of all unreleased bytes plus a read position. Retry resets the position to zero, and done removes the bytes before it.

// File: rtl/tfq_pkg.sv
package tfq_pkg;
  // Read-side control decoded from the MAC retry/done strobes.
  typedef enum logic [1:0] {
    CTL_RUN   = 2'd0,
    CTL_RETRY = 2'd1,
    CTL_DONE  = 2'd2
  } tfq_ctl_e;
endpackage

// File: rtl/tfq_store.sv
module tfq_store #(
  parameter int DEPTH = 3072,
  parameter int WW    = 9,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [WW-1:0] wr_word,
  input  logic [AW-1:0] rd_idx,
  output logic [WW-1:0] rd_word
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_word;
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/tfq_track.sv
module tfq_track
  import tfq_pkg::*;
#(
  parameter int DEPTH = 3072,
  parameter int AW    = 12,
  parameter int CW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_eof,
  input  logic          pop,
  input  logic          pop_eof,
  input  tfq_ctl_e      ctl,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx,
  output logic [CW-1:0] held,
  output logic [CW-1:0] avail,
  output logic [CW-1:0] eof_ahead,
  output logic          sent_eof
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP      = CW'(DEPTH);

  logic [AW-1:0] wr_idx_q, wr_idx_n;
  logic [AW-1:0] rd_idx_q, rd_idx_n;
  logic [AW-1:0] base_q,   base_n;
  logic [CW-1:0] held_q,   held_n;
  logic [CW-1:0] sent_q,   sent_n;
  logic [CW-1:0] eofa_q,   eofa_n;
  logic          seof_q,   seof_n;

  function automatic logic [AW-1:0] ring_inc(input logic [AW-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  // Next-state logic
  always_comb begin
    wr_idx_n = wr_idx_q;
    rd_idx_n = rd_idx_q;
    base_n   = base_q;
    held_n   = held_q;
    sent_n   = sent_q;
    eofa_n   = eofa_q;
    seof_n   = seof_q;

    if (push) begin
      wr_idx_n = ring_inc(wr_idx_q);
      held_n   = held_q + 1'b1;
      if (push_eof) begin
        eofa_n = eofa_q + 1'b1;
      end
    end

    unique case (ctl)
      CTL_RETRY: begin
        rd_idx_n = base_q;
        sent_n   = '0;
        seof_n   = 1'b0;
        if (seof_q) begin
          eofa_n = eofa_n + 1'b1;
        end
      end
      CTL_DONE: begin
        base_n = rd_idx_q;
        held_n = held_n - sent_q;
        sent_n = '0;
        seof_n = 1'b0;
      end
      default: begin
        if (pop) begin
          rd_idx_n = ring_inc(rd_idx_q);
          sent_n   = sent_q + 1'b1;
          if (pop_eof) begin
            eofa_n = eofa_n - 1'b1;
            seof_n = 1'b1;
          end
        end
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      base_q   <= '0;
      held_q   <= '0;
      sent_q   <= '0;
      eofa_q   <= '0;
      seof_q   <= 1'b0;
    end else begin
      wr_idx_q <= wr_idx_n;
      rd_idx_q <= rd_idx_n;
      base_q   <= base_n;
      held_q   <= held_n;
      sent_q   <= sent_n;
      eofa_q   <= eofa_n;
      seof_q   <= seof_n;
    end
  end

  assign wr_idx    = wr_idx_q;
  assign rd_idx    = rd_idx_q;
  assign held      = held_q;
  assign avail     = held_q - sent_q;
  assign eof_ahead = eofa_q;
  assign sent_eof  = seof_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    held_q <= CAP); // R3
  AST_REPLAY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sent_q <= held_q); // R4
  AST_REWIND_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == CTL_RETRY) |=> (avail == $past(held_q) + CW'($past(push)))); // R7
endmodule

// File: rtl/tfq_gate.sv
module tfq_gate
  import tfq_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] avail,
  input  logic [CW-1:0] eof_ahead,
  input  logic          sent_eof,
  input  logic [CW-1:0] thr,
  input  logic          rd_ready,
  input  tfq_ctl_e      ctl,
  output logic          start_ok,
  output logic          underrun
);
  logic urun_q, urun_n;

  assign start_ok = (avail >= thr) || (eof_ahead != '0);

  always_comb begin
    urun_n = (ctl == CTL_RUN) && rd_ready && (avail == '0) && !sent_eof;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      urun_q <= 1'b0;
    end else begin
      urun_q <= urun_n;
    end
  end

  assign underrun = urun_q;

  AST_URUN_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $past(rd_ready)); // R9
endmodule

// File: rtl/tx_replay_fifo.sv
module tx_replay_fifo
  import tfq_pkg::*;
#(
  parameter int DEPTH = 3072,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DW-1:0]                wr_data,
  input  logic                         wr_valid,
  input  logic                         wr_eof,
  output logic                         wr_ready,
  output logic [DW-1:0]                rd_data,
  output logic                         rd_valid,
  output logic                         rd_eof,
  input  logic                         rd_ready,
  input  logic                         tx_retry,
  input  logic                         tx_done,
  input  logic [$clog2(DEPTH+1)-1:0]   start_thr,
  output logic                         start_ok,
  output logic                         underrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WW = DW + 1;
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  tfq_ctl_e      ctl;
  logic          push, pop;
  logic [AW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] held, avail, eof_ahead;
  logic          sent_eof;
  logic [WW-1:0] rd_word;

  // Retry outranks done when both strobe together.
  always_comb begin
    if (tx_retry)     ctl = CTL_RETRY;
    else if (tx_done) ctl = CTL_DONE;
    else              ctl = CTL_RUN;
  end

  assign wr_ready = (held != CAP);
  assign push     = wr_valid && wr_ready;
  assign rd_valid = (avail != '0) && (ctl == CTL_RUN);
  assign pop      = rd_valid && rd_ready;
  assign rd_data  = rd_word[DW-1:0];
  assign rd_eof   = rd_word[DW];

  tfq_store #(.DEPTH(DEPTH), .WW(WW), .AW(AW)) u_store (
    .clk     (clk),
    .wr_en   (push),
    .wr_idx  (wr_idx),
    .wr_word ({wr_eof, wr_data}),
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
  );

  tfq_track #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_eof  (wr_eof),
    .pop       (pop),
    .pop_eof   (rd_eof),
    .ctl       (ctl),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx),
    .held      (held),
    .avail     (avail),
    .eof_ahead (eof_ahead),
    .sent_eof  (sent_eof)
  );

  tfq_gate #(.CW(CW)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .avail     (avail),
    .eof_ahead (eof_ahead),
    .sent_eof  (sent_eof),
    .thr       (start_thr),
    .rd_ready  (rd_ready),
    .ctl       (ctl),
    .start_ok  (start_ok),
    .underrun  (underrun)
  );

  AST_EOF_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_eof) |-> start_ok); // R6
  AST_STROBE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_retry || tx_done) |=> (avail >= $past(avail))); // R10
endmodule

// File: tb/tx_replay_fifo_test.sv
module tx_replay_fifo_test;
  localparam int DEPTH = 3072;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    wr_data;
  logic          wr_valid, wr_eof, wr_ready;
  logic [7:0]    rd_data;
  logic          rd_valid, rd_eof, rd_ready;
  logic          tx_retry, tx_done;
  logic [CW-1:0] start_thr;
  logic          start_ok, underrun;

  int checks = 0;
  int errors = 0;
  logic [8:0] model [$];
  int rd_pos = 0;

  always #4 clk = ~clk;

  tx_replay_fifo uut (
    .clk(clk), .rst_n(rst_n),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_eof(wr_eof), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_eof(rd_eof), .rd_ready(rd_ready),
    .tx_retry(tx_retry), .tx_done(tx_done), .start_thr(start_thr),
    .start_ok(start_ok), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: one write attempt; accepted bytes join the scoreboard.
  task automatic push_byte(input logic [7:0] d, input logic e, output bit took);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_eof = e;
    #1 took = wr_ready;
    @(posedge clk);
    #1 wr_valid = 1'b0;
    if (took) model.push_back({e, d});
  endtask

  task automatic push_frame(input int len, input int seed);
    bit t;
    for (int i = 0; i < len; i++) begin
      push_byte(8'(seed + i * 7), (i == len - 1), t);
      chk(t, "R2 write accepted", int'(t), 1);
    end
  endtask

  // Monitor: one read attempt, compared against the scoreboard.
  task automatic pop_byte(input bit want, input string req);
    bit took;
    @(negedge clk);
    rd_ready = 1'b1;
    #1 took = rd_valid;
    chk(took == want, {req, " rd_valid"}, int'(took), int'(want));
    if (took && rd_pos < model.size())
      chk({rd_eof, rd_data} == model[rd_pos], {req, " byte"},
          int'({rd_eof, rd_data}), int'(model[rd_pos]));
    @(posedge clk);
    #1 rd_ready = 1'b0;
    if (took) rd_pos++;
  endtask

  task automatic strobe(input bit r, input bit d);
    @(negedge clk);
    tx_retry = r; tx_done = d; rd_ready = 1'b1;
    #1 chk(!rd_valid, "R10 no offer during strobe", int'(rd_valid), 0);
    @(posedge clk);
    #1 tx_retry = 1'b0; tx_done = 1'b0; rd_ready = 1'b0;
    if (r) rd_pos = 0;
    else if (d) begin
      for (int i = 0; i < rd_pos; i++) void'(model.pop_front());
      rd_pos = 0;
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit t;
    int cnt;
    rst_n = 1'b0; wr_valid = 0; wr_data = 0; wr_eof = 0; rd_ready = 0;
    tx_retry = 0; tx_done = 0; start_thr = CW'(8);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(wr_ready == 1, "R1 wr_ready", int'(wr_ready), 1);
    chk(rd_valid == 0, "R1 rd_valid", int'(rd_valid), 0);
    chk(start_ok == 0, "R1 start_ok", int'(start_ok), 0);
    chk(underrun == 0, "R1 underrun", int'(underrun), 0);

    // R5: threshold of 8 with a frame still open
    for (int i = 0; i < 7; i++) begin push_byte(8'(16 + i), 1'b0, t); end
    #1 chk(start_ok == 0, "R5 below threshold", int'(start_ok), 0);
    push_byte(8'h30, 1'b0, t);
    #1 chk(start_ok == 1, "R5 at threshold", int'(start_ok), 1);

    // R2: order, then R9 starve with frame open
    for (int i = 0; i < 8; i++) pop_byte(1'b1, "R2 order");
    pop_byte(1'b0, "R9 empty");
    @(negedge clk) #1 chk(underrun == 1, "R9 pulse", int'(underrun), 1);
    @(negedge clk) #1 chk(underrun == 0, "R9 single cycle", int'(underrun), 0);

    // R7: retry replays from frame start
    strobe(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) pop_byte(1'b1, "R7 replay");
    push_byte(8'h5A, 1'b1, t);
    for (int i = 0; i < 6; i++) pop_byte(1'b1, "R7 replay rest");
    pop_byte(1'b0, "R9 after end");
    @(negedge clk) #1 chk(underrun == 0, "R9 no pulse after frame end", int'(underrun), 0);
    strobe(1'b0, 1'b1);
    pop_byte(1'b0, "R8 freed");

    // R6: short frame with end below threshold
    push_frame(3, 64);
    #1 chk(start_ok == 1, "R6 eof grants start", int'(start_ok), 1);
    push_frame(4, 96);
    // R11: back to back frames
    for (int i = 0; i < 7; i++) pop_byte(1'b1, "R11 back to back");
    strobe(1'b0, 1'b1);
    #1 chk(start_ok == 0, "R8 empty after done", int'(start_ok), 0);

    // R10: retry wins over done
    push_frame(5, 140);
    pop_byte(1'b1, "R10 pre");
    pop_byte(1'b1, "R10 pre");
    strobe(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) pop_byte(1'b1, "R10 retry wins");
    strobe(1'b0, 1'b1);

    // R3: capacity
    cnt = 0;
    for (int i = 0; i < DEPTH + 4; i++) begin
      push_byte(8'(i), (i % 64 == 63), t);
      if (t) cnt++;
    end
    chk(cnt == DEPTH, "R3 capacity", cnt, DEPTH);
    #1 chk(wr_ready == 0, "R3 full", int'(wr_ready), 0);

    // R4: reading alone frees nothing
    for (int i = 0; i < 100; i++) pop_byte(1'b1, "R4 read while full");
    #1 chk(wr_ready == 0, "R4 still full", int'(wr_ready), 0);
    strobe(1'b1, 1'b0);
    for (int i = 0; i < 64; i++) pop_byte(1'b1, "R4 first frame");
    strobe(1'b0, 1'b1);
    cnt = 0;
    for (int i = 0; i < 66; i++) begin
      push_byte(8'(i + 3), (i % 64 == 63), t);
      if (t) cnt++;
    end
    chk(cnt == 64, "R4 freed space", cnt, 64);

    // drain
    for (int f = 0; f < 48; f++) begin
      for (int i = 0; i < 64; i++) pop_byte(1'b1, "R2 drain");
      strobe(1'b0, 1'b1);
    end
    pop_byte(1'b0, "R8 drained");
    chk(model.size() == 0, "R8 scoreboard empty", model.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule